// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Detector

This block runs entirely in the master clock domain and works out how many master clock cycles make up one frame of the left/right frame clock. The frame clock enters unsynchronised and passes through a short synchroniser. The block counts master clock cycles between successive rising edges and sorts each measured period into one of seven supported oversampling ratios. The result drives the sample-rate-dependent logic further down the chip.

Each ratio accepts a period of ±32 cycles around its nominal value, so phase wander between the two clocks does not make the reported ratio flicker. A ratio is reported as valid only once two consecutive periods fall into the same ratio. A period that matches no ratio raises an error. A frame clock that stops long enough to saturate the counter also raises an error.

Top module: `clk_ratio_detector`

## Requirements
- R1: While reset is asserted and after it is released, `code_o` is 0 and `valid_o` and `err_o` are 0. `err_o` stays 0 until a frame clock has been seen.
- R2: `frame_clk_i` passes through two synchroniser flops and one edge-detect flop. A frame rise first sampled at master clock edge A changes the outputs at edge A+2 and no earlier.
- R3: A period is the number of master clock rising edges between two synchronised frame rises. The first rise after reset or after a saturation only arms the measurement and leaves all outputs unchanged.
- R4: The codes run in ascending order of ratio: 128→0, 192→1, 256→2, 384→3, 512→4, 768→5, 1152→6.
- R5: A period P matches a ratio N when N−32 ≤ P ≤ N+32. When two windows overlap (P = 160 or P = 224), the lower ratio wins.
- R6: A period that matches no window raises `err_o` and clears `valid_o`. This covers periods below 96, above 1184, and those in the gaps between windows. The next matching period clears `err_o`.
- R7: `valid_o` rises only when the current period and the previous period match the same code. A matching period with a different code from the previous period clears `valid_o`.
- R8: Periods that wander within one window keep `valid_o` high and `code_o` unchanged.
- R9: If no frame rise arrives for 2^CNT_W−1 cycles, the counter saturates. The block then clears `valid_o`, raises `err_o`, and re-arms as described in R3.
- R10: `code_o` changes only when a ratio becomes valid. It holds the last valid code through errors and through loss of qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_clk_i | input | 1 | Raw frame (left/right) clock |
| code_o | output | 3 | Detected ratio code (0..6) |
| valid_o | output | 1 | Ratio qualified over two consecutive periods |
| err_o | output | 1 | Last period matched no ratio, or frame clock stopped |

## Verification
Several properties hold on every cycle and are checked continuously:
- `valid_o` and `err_o` are never high together.
- `valid_o` only rises on the cycle after a detected frame edge.
- `code_o` stays stable while `valid_o` stays high.
- The counter holds at saturation, and saturation forces the error state.
- An edge pulse never lasts more than one cycle.

Other behaviours can only be shown through the bench's scenarios:
- The mapping of each period to a code, including the window edges and the overlap rule.
- The two-period qualification and the exact output latency.
- Jitter tolerance and the re-arming after a stopped frame clock.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int NUM_RATIO = 7;
  localparam int CODE_W    = 3;

  function automatic int unsigned ratio_of(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction
endpackage

// File: rtl/frame_sync.sv
module frame_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its one-cycle delay
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], frame_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W:0]   period_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (rise_i)  cnt_q <= '0;
    else if (!sat_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign sat_o    = (cnt_q == CNT_MAX);
  assign period_o = {1'b0, cnt_q} + 1'b1;

  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !rise_i) |=> sat_o);
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import clk_ratio_pkg::*;
#(
  parameter int PW  = 12,
  parameter int TOL = 32
) (
  input  logic [PW-1:0]     period_i,
  output logic [CODE_W-1:0] code_o,
  output logic              hit_o
);
  logic [NUM_RATIO-1:0] in_win;

  for (genvar i = 0; i < NUM_RATIO; i++) begin : g_win
    localparam int unsigned LO = ratio_of(i) - TOL;
    localparam int unsigned HI = ratio_of(i) + TOL;
    assign in_win[i] = (32'(period_i) >= LO) && (32'(period_i) <= HI);
  end

  // overlapping windows: lowest ratio wins
  always_comb begin
    code_o = '0;
    for (int i = NUM_RATIO - 1; i >= 0; i--)
      if (in_win[i]) code_o = CODE_W'(i);
  end

  assign hit_o = |in_win;
endmodule

// File: rtl/clk_ratio_detector.sv
module clk_ratio_detector
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_clk_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int PW = CNT_W + 1;

  logic              rise_w;
  logic              sat_w;
  logic [PW-1:0]     period_w;
  logic [CODE_W-1:0] cls_code_w;
  logic              cls_hit_w;

  logic              armed_q;
  logic              prev_hit_q;
  logic [CODE_W-1:0] prev_code_q;

  frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_clk_i),
    .rise_o  (rise_w)
  );

  period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise_w),
    .period_o (period_w),
    .sat_o    (sat_w)
  );

  ratio_classifier #(.PW(PW), .TOL(TOL)) u_cls (
    .period_i (period_w),
    .code_o   (cls_code_w),
    .hit_o    (cls_hit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      prev_hit_q  <= 1'b0;
      prev_code_q <= '0;
      code_o      <= '0;
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
    end else if (rise_w) begin
      armed_q <= 1'b1;
      if (armed_q) begin
        if (cls_hit_w) begin
          err_o       <= 1'b0;
          prev_hit_q  <= 1'b1;
          prev_code_q <= cls_code_w;
          if (prev_hit_q && (prev_code_q == cls_code_w)) begin
            valid_o <= 1'b1;
            code_o  <= cls_code_w;
          end else begin
            valid_o <= 1'b0;
          end
        end else begin
          valid_o    <= 1'b0;
          err_o      <= 1'b1;
          prev_hit_q <= 1'b0;
        end
      end
    end else if (sat_w && armed_q) begin
      // frame clock stopped: drop qualification and re-arm
      armed_q    <= 1'b0;
      prev_hit_q <= 1'b0;
      valid_o    <= 1'b0;
      err_o      <= 1'b1;
    end
  end

  assert_err_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  assert_valid_after_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rise_w));

  assert_code_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> $stable(code_o));

  assert_sat_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_w && armed_q && !rise_w) |=> (!valid_o && err_o));
endmodule

// File: tb/tb_clk_ratio_detector.sv
module tb_clk_ratio_detector;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_clk_i = 1'b0;
  logic [2:0] code_o;
  logic       valid_o;
  logic       err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int last_code = 0;

  always #4 clk_i = ~clk_i;

  clk_ratio_detector dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_clk_i (frame_clk_i),
    .code_o      (code_o),
    .valid_o     (valid_o),
    .err_o       (err_o)
  );

  typedef struct packed {
    logic [15:0] period;
    logic [2:0]  code;
    logic        valid;
    logic        err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{16'd128,  3'd0, 1'b1, 1'b0},  // R4
    '{16'd192,  3'd1, 1'b1, 1'b0},
    '{16'd256,  3'd2, 1'b1, 1'b0},
    '{16'd384,  3'd3, 1'b1, 1'b0},
    '{16'd512,  3'd4, 1'b1, 1'b0},
    '{16'd768,  3'd5, 1'b1, 1'b0},
    '{16'd1152, 3'd6, 1'b1, 1'b0},
    '{16'd96,   3'd0, 1'b1, 1'b0},  // R5 low edge
    '{16'd160,  3'd0, 1'b1, 1'b0},  // R5 overlap
    '{16'd161,  3'd1, 1'b1, 1'b0},
    '{16'd224,  3'd1, 1'b1, 1'b0},  // R5 overlap
    '{16'd225,  3'd2, 1'b1, 1'b0},
    '{16'd1184, 3'd6, 1'b1, 1'b0},  // R5 high edge
    '{16'd1185, 3'd0, 1'b0, 1'b1},  // R6
    '{16'd95,   3'd0, 1'b0, 1'b1},  // R6
    '{16'd300,  3'd0, 1'b0, 1'b1},  // R6 gap
    '{16'd1120, 3'd6, 1'b1, 1'b0},
    '{16'd1119, 3'd0, 1'b0, 1'b1}   // R6 gap
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int c, input int v, input int e);
    chk(req, "code_o", int'(code_o), c);
    chk(req, "valid_o", int'(valid_o), v);
    chk(req, "err_o", int'(err_o), e);
  endtask

  // starts and ends at a falling clock edge; one rise at the start
  task automatic frame_period(input int n);
    frame_clk_i = 1'b1;
    repeat (n / 2) @(negedge clk_i);
    frame_clk_i = 1'b0;
    repeat (n - n / 2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_out("R1", 0, 0, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_out("R1", 0, 0, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 4; k++) frame_period(int'(VEC[i].period));
      if (VEC[i].valid) last_code = int'(VEC[i].code);
      chk(VEC[i].valid ? "R4/R5" : "R6", "valid_o", int'(valid_o), int'(VEC[i].valid));
      chk(VEC[i].valid ? "R4/R5" : "R6", "err_o", int'(err_o), int'(VEC[i].err));
      chk("R10", "code_o", int'(code_o), last_code);
    end

    // stopped frame clock
    repeat (2200) @(negedge clk_i);
    chk_out("R9", last_code, 0, 1);

    // re-arm: first rise ignored
    frame_period(256);
    chk_out("R3", last_code, 0, 1);
    // one matching period: error clears, not yet valid
    frame_period(256);
    chk_out("R7", last_code, 0, 0);
    // latency of the qualifying rise
    frame_clk_i = 1'b1;
    @(negedge clk_i);
    chk("R2", "valid_o after edge A", int'(valid_o), 0);
    @(negedge clk_i);
    chk("R2", "valid_o after edge A+1", int'(valid_o), 0);
    @(negedge clk_i);
    chk("R2", "valid_o after edge A+2", int'(valid_o), 1);
    chk("R2", "code_o after edge A+2", int'(code_o), 2);
    repeat (128 - 3) @(negedge clk_i);
    frame_clk_i = 1'b0;
    repeat (128) @(negedge clk_i);

    // jitter inside the 256 window
    frame_period(250);
    chk_out("R8", 2, 1, 0);
    frame_period(262);
    chk_out("R8", 2, 1, 0);
    frame_period(250);
    chk_out("R8", 2, 1, 0);
    frame_period(288);
    chk_out("R8", 2, 1, 0);

    // ratio change: qualification drops, code holds, then requalifies
    frame_period(384);
    frame_period(384);
    chk_out("R7", 2, 0, 0);
    frame_period(384);
    chk_out("R7", 3, 1, 0);

    // reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk_out("R1", 0, 0, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_out("R1", 0, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule